// File: doc/BRIEF.md
# Replayable Maximal-Length LFSR

This block is a pseudo-random state generator built on a linear feedback shift register. Its register width is a parameter that may be any value from 2 to 128 bits. Every width takes its feedback taps from a fixed internal table of primitive polynomials, so the register always runs a maximal-length sequence. A parameter selects the feedback structure. The external-XOR (shift-and-feed) form and the internal-XOR (shift-and-fold) form are both available. The output is the raw register state.

The block is meant for memory and bus stress generators. A client writes a burst of addresses or data taken from the sequence, then rewinds and walks the same values again to verify them. For that purpose there is a snapshot register. A save pulse copies the live state into it. A restore pulse copies it back, so the register replays exactly the values that followed the save point. The replay can start at any point in the sequence, not only at the seed. A seed port reseeds the register at any time. A zero seed is not allowed to lock up the register.

A small command decoder turns the control inputs into one command per cycle: `CMD_IDLE` (hold), `CMD_SEED` (load the sanitised seed), `CMD_RECALL` (copy the snapshot back) and `CMD_STEP` (advance one position). The state register moves from its present value to the value that the command for that cycle selects. The snapshot register is updated on its own path and does not depend on the command.

Top module: `lfsr_replay`

## Requirements
- R1: After reset the state is INIT_SEED (if INIT_SEED is zero, the value 1) and the snapshot holds the same value. A restore issued before any save therefore returns to that value.
- R2: In a cycle with no seed load, no restore and step_en low, the state does not change.
- R3: With step_en high the state moves one LFSR step per clock. Starting from state 1 it passes through 2^WIDTH-1 distinct non-zero values and is back at 1 after exactly 2^WIDTH-1 steps. This holds for both feedback styles (STYLE value FB_FIBONACCI or FB_GALOIS).
- R4: seed_load with a non-zero seed_value makes the state equal to seed_value one clock later.
- R5: seed_load with seed_value equal to zero makes the state equal to 1 (only bit 0 set) one clock later.
- R6: The state output is never zero while out of reset.
- R7: A save pulse stores the state as it was before any update in that cycle. A later restore reloads it, and the steps that follow repeat the values seen after the save.
- R8: Within one cycle, seed load wins over restore, and restore wins over step. Save works independently of the other three controls.
- R9: If save and restore are both high in one cycle (without seed load), the state takes the old snapshot and the snapshot takes the state from before the edge.
- R10: The sequence is deterministic. From a given state, a step always leads to the same next state, whether that state was reached by stepping, by seeding or by restoring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_load | input | 1 | Load seed_value into the register this cycle |
| seed_value | input | WIDTH | Seed value; zero is replaced by 1 |
| step_en | input | 1 | Advance the register one step |
| save | input | 1 | Copy the current state into the snapshot |
| restore | input | 1 | Copy the snapshot into the state |
| state_out | output | WIDTH | Current register state |

## Verification
The first stimulus is a free-running walk through one full period at two widths, one for each feedback style. This walk separates a maximal tap set from a short-cycling or stuck one, because any repeated or missing state is seen before the wrap-around. The step map learned in that walk drives a reference model. Directed cycles then combine seed load, restore, step and save in the same cycle, which separates a correct priority order from a wrong one and shows whether save captures the state before or after the update. A save/step/restore/replay run and a long stream of pseudo-random control combinations, zero seeds included, separate a snapshot that is truly captured and reloaded from one that tracks the live state.

// File: rtl/lfsr_replay_pkg.sv
package lfsr_replay_pkg;

    typedef enum logic [0:0] {
        FB_FIBONACCI = 1'b0,
        FB_GALOIS    = 1'b1
    } fb_style_e;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_SEED   = 2'd1,
        CMD_RECALL = 2'd2,
        CMD_STEP   = 2'd3
    } cmd_e;

    localparam int unsigned MAX_WIDTH = 128;

    // Builds a mask from up to four tap stage numbers (1-based, 0 = unused).
    function automatic logic [MAX_WIDTH-1:0] taps(input int a, input int b,
                                                  input int c, input int d);
        logic [MAX_WIDTH-1:0] m;
        m = '0;
        if (a > 0) m[a-1] = 1'b1;
        if (b > 0) m[b-1] = 1'b1;
        if (c > 0) m[c-1] = 1'b1;
        if (d > 0) m[d-1] = 1'b1;
        return m;
    endfunction

    function automatic logic [MAX_WIDTH-1:0] taps_narrow(input int w);
        logic [MAX_WIDTH-1:0] m;
        case (w)
            2:  m = taps(2,1,0,0);      3:  m = taps(3,2,0,0);
            4:  m = taps(4,3,0,0);      5:  m = taps(5,3,0,0);
            6:  m = taps(6,5,0,0);      7:  m = taps(7,6,0,0);
            8:  m = taps(8,6,5,4);      9:  m = taps(9,5,0,0);
            10: m = taps(10,7,0,0);     11: m = taps(11,9,0,0);
            12: m = taps(12,6,4,1);     13: m = taps(13,4,3,1);
            14: m = taps(14,5,3,1);     15: m = taps(15,14,0,0);
            16: m = taps(16,15,13,4);   17: m = taps(17,14,0,0);
            18: m = taps(18,11,0,0);    19: m = taps(19,6,2,1);
            20: m = taps(20,17,0,0);    21: m = taps(21,19,0,0);
            22: m = taps(22,21,0,0);    23: m = taps(23,18,0,0);
            24: m = taps(24,23,22,17);  25: m = taps(25,22,0,0);
            26: m = taps(26,6,2,1);     27: m = taps(27,5,2,1);
            28: m = taps(28,25,0,0);    29: m = taps(29,27,0,0);
            30: m = taps(30,6,4,1);     31: m = taps(31,28,0,0);
            32: m = taps(32,22,2,1);    33: m = taps(33,20,0,0);
            34: m = taps(34,27,2,1);    35: m = taps(35,33,0,0);
            36: m = taps(36,25,0,0);    37: m = taps(37,5,4,3) | taps(2,1,0,0);
            38: m = taps(38,6,5,1);     39: m = taps(39,35,0,0);
            40: m = taps(40,38,21,19);  41: m = taps(41,38,0,0);
            42: m = taps(42,41,20,19);  43: m = taps(43,42,38,37);
            44: m = taps(44,43,18,17);  45: m = taps(45,44,42,41);
            46: m = taps(46,45,26,25);  47: m = taps(47,42,0,0);
            48: m = taps(48,47,21,20);  49: m = taps(49,40,0,0);
            50: m = taps(50,49,24,23);  51: m = taps(51,50,36,35);
            52: m = taps(52,49,0,0);    53: m = taps(53,52,38,37);
            54: m = taps(54,53,18,17);  55: m = taps(55,31,0,0);
            56: m = taps(56,55,35,34);  57: m = taps(57,50,0,0);
            58: m = taps(58,39,0,0);    59: m = taps(59,58,38,37);
            60: m = taps(60,59,0,0);    61: m = taps(61,60,46,45);
            62: m = taps(62,61,6,5);    63: m = taps(63,62,0,0);
            64: m = taps(64,63,61,60);
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [MAX_WIDTH-1:0] taps_wide(input int w);
        logic [MAX_WIDTH-1:0] m;
        case (w)
            65:  m = taps(65,47,0,0);      66:  m = taps(66,65,57,56);
            67:  m = taps(67,66,58,57);    68:  m = taps(68,59,0,0);
            69:  m = taps(69,67,42,40);    70:  m = taps(70,69,55,54);
            71:  m = taps(71,65,0,0);      72:  m = taps(72,66,25,19);
            73:  m = taps(73,48,0,0);      74:  m = taps(74,73,59,58);
            75:  m = taps(75,74,65,64);    76:  m = taps(76,75,41,40);
            77:  m = taps(77,76,47,46);    78:  m = taps(78,77,59,58);
            79:  m = taps(79,70,0,0);      80:  m = taps(80,79,43,42);
            81:  m = taps(81,77,0,0);      82:  m = taps(82,79,47,44);
            83:  m = taps(83,82,38,37);    84:  m = taps(84,71,0,0);
            85:  m = taps(85,84,58,57);    86:  m = taps(86,85,74,73);
            87:  m = taps(87,74,0,0);      88:  m = taps(88,87,17,16);
            89:  m = taps(89,51,0,0);      90:  m = taps(90,89,72,71);
            91:  m = taps(91,90,8,7);      92:  m = taps(92,91,80,79);
            93:  m = taps(93,91,0,0);      94:  m = taps(94,73,0,0);
            95:  m = taps(95,84,0,0);      96:  m = taps(96,94,49,47);
            97:  m = taps(97,91,0,0);      98:  m = taps(98,87,0,0);
            99:  m = taps(99,97,54,52);    100: m = taps(100,63,0,0);
            101: m = taps(101,100,95,94);  102: m = taps(102,101,36,35);
            103: m = taps(103,94,0,0);     104: m = taps(104,103,94,93);
            105: m = taps(105,89,0,0);     106: m = taps(106,91,0,0);
            107: m = taps(107,105,44,42);  108: m = taps(108,77,0,0);
            109: m = taps(109,108,103,102);110: m = taps(110,109,98,97);
            111: m = taps(111,101,0,0);    112: m = taps(112,110,69,67);
            113: m = taps(113,104,0,0);    114: m = taps(114,113,33,32);
            115: m = taps(115,114,101,100);116: m = taps(116,115,46,45);
            117: m = taps(117,115,99,97);  118: m = taps(118,85,0,0);
            119: m = taps(119,111,0,0);    120: m = taps(120,113,9,2);
            121: m = taps(121,103,0,0);    122: m = taps(122,121,63,62);
            123: m = taps(123,121,0,0);    124: m = taps(124,87,0,0);
            125: m = taps(125,124,18,17);  126: m = taps(126,125,90,89);
            127: m = taps(127,126,0,0);    128: m = taps(128,126,101,99);
            default: m = '0;
        endcase
        return m;
    endfunction

    // Feedback mask for the external-XOR form: bit k-1 set for tap stage k.
    function automatic logic [MAX_WIDTH-1:0] fib_mask(input int w);
        return (w <= 64) ? taps_narrow(w) : taps_wide(w);
    endfunction

    // Fold mask for the internal-XOR form: same polynomial, bit 0 for x^0.
    function automatic logic [MAX_WIDTH-1:0] galois_mask(input int w);
        logic [MAX_WIDTH-1:0] m;
        m = fib_mask(w);
        m[w-1] = 1'b0;
        return {m[MAX_WIDTH-2:0], 1'b1};
    endfunction

endpackage

// File: rtl/lfsr_cmd_decode.sv
module lfsr_cmd_decode (
    input  logic                  seed_load,
    input  logic                  restore,
    input  logic                  step_en,
    output lfsr_replay_pkg::cmd_e cmd
);
    import lfsr_replay_pkg::*;

    // Fixed priority: seed, then recall, then step.
    always_comb begin
        if (seed_load)    cmd = CMD_SEED;
        else if (restore) cmd = CMD_RECALL;
        else if (step_en) cmd = CMD_STEP;
        else              cmd = CMD_IDLE;
    end
endmodule

// File: rtl/lfsr_next.sv
module lfsr_next #(
    parameter int                        WIDTH = 8,
    parameter lfsr_replay_pkg::fb_style_e STYLE = lfsr_replay_pkg::FB_FIBONACCI
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    import lfsr_replay_pkg::*;

    localparam logic [MAX_WIDTH-1:0] FIB_FULL = fib_mask(WIDTH);
    localparam logic [MAX_WIDTH-1:0] GAL_FULL = galois_mask(WIDTH);
    localparam logic [WIDTH-1:0]     FIB_TAP  = FIB_FULL[WIDTH-1:0];
    localparam logic [WIDTH-1:0]     GAL_TAP  = GAL_FULL[WIDTH-1:0];

    generate
        if (STYLE == FB_FIBONACCI) begin : g_fib
            logic feed;
            always_comb begin
                feed = ^(cur & FIB_TAP);
                nxt  = {cur[WIDTH-2:0], feed};
            end
        end else begin : g_gal
            always_comb begin
                nxt = {cur[WIDTH-2:0], 1'b0} ^ (cur[WIDTH-1] ? GAL_TAP : '0);
            end
        end
    endgenerate
endmodule

// File: rtl/lfsr_shadow.sv
module lfsr_shadow #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = WIDTH'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save,
    input  logic [WIDTH-1:0] live,
    output logic [WIDTH-1:0] snap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= RESET_VAL;
        else if (save) snap <= live;
    end
endmodule

// File: rtl/lfsr_replay.sv
module lfsr_replay #(
    parameter int                         WIDTH     = 8,
    parameter lfsr_replay_pkg::fb_style_e STYLE     = lfsr_replay_pkg::FB_FIBONACCI,
    parameter logic [WIDTH-1:0]           INIT_SEED = WIDTH'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_value,
    input  logic             step_en,
    input  logic             save,
    input  logic             restore,
    output logic [WIDTH-1:0] state_out
);
    import lfsr_replay_pkg::*;

    localparam logic [WIDTH-1:0] ONE       = WIDTH'(1);
    localparam logic [WIDTH-1:0] SAFE_INIT = (INIT_SEED == '0) ? ONE : INIT_SEED;

    cmd_e             cmd;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] shadow_q;
    logic [WIDTH-1:0] seed_safe;

    lfsr_cmd_decode u_decode (
        .seed_load (seed_load),
        .restore   (restore),
        .step_en   (step_en),
        .cmd       (cmd)
    );

    lfsr_next #(.WIDTH(WIDTH), .STYLE(STYLE)) u_next (
        .cur (state_q),
        .nxt (stepped)
    );

    lfsr_shadow #(.WIDTH(WIDTH), .RESET_VAL(SAFE_INIT)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .save  (save),
        .live  (state_q),
        .snap  (shadow_q)
    );

    always_comb begin
        seed_safe = (seed_value == '0) ? ONE : seed_value;
        unique case (cmd)
            CMD_IDLE:   state_d = state_q;
            CMD_SEED:   state_d = seed_safe;
            CMD_RECALL: state_d = shadow_q;
            CMD_STEP:   state_d = stepped;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SAFE_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_out = state_q;
    end
endmodule

// File: rtl/lfsr_replay_chk.sv
module lfsr_replay_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_value,
    input logic             step_en,
    input logic             save,
    input logic             restore,
    input logic [WIDTH-1:0] state_out,
    input logic [WIDTH-1:0] shadow_q
);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !restore && !step_en) |=> $stable(state_out));

    a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load && !restore) |=> (state_out != $past(state_out)));

    a_r4_seed_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value != '0) |=> (state_out == $past(seed_value)));

    a_r5_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value == '0) |=> (state_out == WIDTH'(1)));

    a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_out != '0);

    a_r7_replay_point: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(save) && restore && !seed_load) |=> (state_out == $past(state_out, 2)));

    a_r8_recall_over_step: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && step_en && !seed_load) |=> (state_out == $past(shadow_q)));

    a_r9_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (save && restore && !seed_load) |=>
            (state_out == $past(shadow_q) && shadow_q == $past(state_out)));
endmodule

bind lfsr_replay lfsr_replay_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .step_en    (step_en),
    .save       (save),
    .restore    (restore),
    .state_out  (state_out),
    .shadow_q   (shadow_q)
);

// File: tb/lfsr_replay_tb.sv
module lfsr_replay_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       ld, st, sv, rs;
    logic [7:0] seed;
    logic [7:0] q8;
    logic       st5;
    logic [4:0] q5;

    lfsr_replay #(.WIDTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .seed_load(ld), .seed_value(seed),
        .step_en(st), .save(sv), .restore(rs), .state_out(q8)
    );

    lfsr_replay #(.WIDTH(5), .STYLE(lfsr_replay_pkg::FB_GALOIS)) u_dut_w5 (
        .clk(clk), .rst_n(rst_n), .seed_load(1'b0), .seed_value(5'd0),
        .step_en(st5), .save(1'b0), .restore(1'b0), .state_out(q5)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int next_of [256];
    int m_state, m_shadow;
    int lcg = 12345;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one cycle of controls, advance the reference model, compare.
    task automatic cyc(string tag, bit l, int s, bit e, bit v, bit r);
        int pre;
        ld = l; seed = 8'(s); st = e; sv = v; rs = r;
        @(posedge clk);
        pre = m_state;
        if (l)      m_state = (s == 0) ? 1 : s;
        else if (r) m_state = m_shadow;
        else if (e) m_state = next_of[m_state];
        if (v) m_shadow = pre;
        #1;
        check(tag, int'(q8), m_state);
    endtask

    initial begin
        int seen [256];
        int seen5 [32];
        int prev;
        int rec [20];
        ld = 0; seed = 0; st = 0; sv = 0; rs = 0; st5 = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 reset state w8", int'(q8), 1);
        check("R1 reset state w5", int'(q5), 1);

        // R3: full period of the 8-bit external-XOR register, learning the step map.
        for (int i = 0; i < 256; i++) seen[i] = 0;
        prev = int'(q8);
        st = 1;
        for (int i = 1; i <= 255; i++) begin
            @(posedge clk); #1;
            next_of[prev] = int'(q8);
            if (i < 255) begin
                check("R3 w8 distinct", seen[q8] + (q8 == 0 ? 1 : 0) + (q8 == 1 ? 1 : 0), 0);
                seen[q8] = 1;
            end
            prev = int'(q8);
        end
        st = 0;
        check("R3 w8 period wraps to 1", int'(q8), 1);

        // R3: full period of the 5-bit internal-XOR register.
        for (int i = 0; i < 32; i++) seen5[i] = 0;
        st5 = 1;
        for (int i = 1; i <= 31; i++) begin
            @(posedge clk); #1;
            if (i < 31) begin
                check("R3 w5 distinct", seen5[q5] + (q5 == 0 ? 1 : 0) + (q5 == 1 ? 1 : 0), 0);
                seen5[q5] = 1;
            end
        end
        st5 = 0;
        check("R3 w5 period wraps to 1", int'(q5), 1);
        @(posedge clk); #1;
        check("R2 w5 holds without step", int'(q5), 1);

        m_state = 1; m_shadow = 1;
        cyc("R1 restore before save gives reset seed", 0, 0, 1, 0, 1);
        cyc("R2 idle hold", 0, 0, 0, 0, 0);
        cyc("R4 seed load", 1, 8'h5a, 0, 0, 0);
        cyc("R5 zero seed becomes 1", 1, 0, 0, 0, 0);
        cyc("R8 seed beats restore and step", 1, 8'hc3, 1, 0, 1);
        cyc("R3 step", 0, 0, 1, 0, 0);
        cyc("R7 save while stepping keeps pre-edge state", 0, 0, 1, 1, 0);
        cyc("R8 restore beats step", 0, 0, 1, 0, 1);
        cyc("R9 swap step", 0, 0, 1, 0, 0);
        cyc("R9 save with restore swaps", 0, 0, 0, 1, 1);
        cyc("R9 restore returns swapped value", 0, 0, 0, 0, 1);

        // R7: save, run, rewind, replay.
        cyc("R7 save point", 0, 0, 0, 1, 0);
        for (int i = 0; i < 20; i++) begin
            cyc("R7 first run", 0, 0, 1, 0, 0);
            rec[i] = int'(q8);
        end
        cyc("R7 rewind", 0, 0, 0, 0, 1);
        for (int i = 0; i < 20; i++) begin
            cyc("R7 replay step", 0, 0, 1, 0, 0);
            check("R7 replay matches first run", int'(q8), rec[i]);
        end

        // R10: mixed pseudo-random controls against the model.
        for (int i = 0; i < 3000; i++) begin
            lcg = lcg * 1103515245 + 12345;
            cyc("R10 mixed controls", (lcg[20:17] == 4'h0), (lcg[9] ? int'(lcg[31:24]) : 0),
                lcg[18] | lcg[19], (lcg[22:21] == 2'b00), (lcg[26:24] == 3'b000));
            check("R6 never zero", int'(q8 == 0), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule